// File: doc/BRIEF.md
# Remote Framebuffer Bus Bridge

This block turns word-wide register writes into cycles on a parallel 16-bit command/data bus that serves up to two display chips, each with its own chip-select line. Register writes emit command or parameter cycles. A 32-bit data write emits two data cycles. Read triggers fetch a word from one chip into a receive buffer. A pixel counter is decremented by every data or read access.

Writing the control register with the trigger bit set can start a frame push. The bridge then streams 16-bit pixels from a memory read port. Each word it accepts becomes one bus write to the chips latched at the start. The memory port is held off while a bus cycle is in flight. When the last cycle has finished, the bridge gives the display controller a one-clock frame-done pulse. While a frame runs, register writes that would start a bus cycle are stalled through `reg_ready`.

Register accesses are combinational reads and single-cycle writes. `reg_addr` is a word index. Every bus cycle has the same shape: one setup clock with chip-select and data driven, then one strobe clock, then a clock with chip-select released.

Top module: `rfb_bridge`

## Requirements
- R1: After reset the control word (index 2) reads 0x2, both config words (indices 10, 11) read 0x00310000, status (index 1) reads 0x1, and the pixel counter (index 3) reads 0.
- R2: Stored values are masked as follows:
  - sysconfig (index 0): 0x19
  - control: bits 3:0
  - config words: 0x003F1FFF
  - data-cycle words (indices 12..17): 0x0F1F0F1F
  - line number (index 4): 11 bits
  - on/off timing (indices 18, 19): 0x3FFFFFFF
  - cycle timing (indices 20, 21): 0x0FFFFFFF
  - sync widths (indices 22, 23): 16 bits
- R3: Control bit 0 is enable, bit 1 is bypass, bit 2 selects chip 0 and bit 3 selects chip 1. A write to index 5 emits one command cycle (`lcd_dc`=0) carrying `reg_wdata[15:0]`, with `lcd_cs` equal to control bits 3:2. With no chip selected, no cycle is emitted.
- R4: A write to index 6 emits one data cycle (`lcd_dc`=1) carrying `reg_wdata[15:0]` to every selected chip.
- R5: A write to index 7 emits two data cycles to the selected chips: `reg_wdata[15:0]` first, then `reg_wdata[31:16]`.
- R6: Each bus write cycle works as follows:
  - Setup clock: `lcd_cs` is non-zero, `lcd_we` is low, and the data is valid.
  - Strobe clock: `lcd_we` is high for exactly one clock, with `lcd_cs`, `lcd_dc` and `lcd_wdata` unchanged.
  - Following clock: `lcd_cs` is released.
- R7: A write to index 8 (data read, `lcd_dc`=1) or index 9 (status read, `lcd_dc`=0) runs one read cycle on a single chip only, chip 0 taking priority over chip 1. The captured word reads back at index 8 or 9 in bits 15:0.
- R8: Each write to index 7, 8 or 9 decrements the pixel counter by one, wrapping from 0 to all ones.
- R9: A control write with bit 4 set starts a frame only if all of these hold:
  - the new enable bit is 1 and the new bypass bit is 0;
  - no frame is running;
  - `disp_rfb_mode` is 1;
  - no bit of 3:2 is set in both config words.
- R10: A frame reads pixel-counter words starting at `gfx_base`, with `mem_addr` stepping by 2 for each accepted word. It emits one data write per word to the latched chips and decrements the counter to 0. Status bit 8 is 1 while the frame runs. `mem_ready` is low while a bus cycle is in flight.
- R11: `frame_done` pulses for one clock after the last frame cycle completes. A frame started with a zero counter emits no cycle and still pulses `frame_done`.
- R12: While a frame runs or a cycle is outstanding, `reg_ready` is low for writes to indices 5..9. Those writes are carried out after the frame, in order.
- R13: A sysconfig write with bit 1 set returns every register to its reset value, aborts any frame, and then stores the written value masked with 0x19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write request, held until accepted |
| reg_addr | input | 6 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| reg_ready | output | 1 | Write accepted on this edge when high |
| disp_rfb_mode | input | 1 | Display controller routes its output to this bridge |
| gfx_base | input | ADDR_W | Graphics layer base byte address |
| mem_addr | output | ADDR_W | Byte address of the next pixel word |
| mem_valid | input | 1 | Memory word available |
| mem_rdata | input | 16 | Memory pixel word |
| mem_ready | output | 1 | Bridge can take a memory word |
| frame_done | output | 1 | One-clock pulse at frame end |
| lcd_cs | output | 2 | Chip-selects, bit 0 = chip 0 |
| lcd_dc | output | 1 | 0 = command/status, 1 = data |
| lcd_wdata | output | 16 | Bus write data |
| lcd_we | output | 1 | Write strobe |
| lcd_re | output | 1 | Read strobe |
| lcd_rdata | input | 16 | Bus read data |

## Verification
The assertions rely on a few conditions at the block's inputs:
- `reg_wr` and its address and data are held steady until `reg_ready` is seen high.
- `mem_rdata` is valid whenever `mem_valid` is high.
- `lcd_rdata` is stable during the read strobe.

The stimulus respects these conditions. Inputs change only on the falling edge. A write task keeps the request asserted until the accepting edge. The bench memory derives its data combinationally from `mem_addr`. The chip model derives its read data from `lcd_cs` and `lcd_dc` alone. The stimulus also toggles `mem_valid` to exercise backpressure. It never issues a soft reset while a frame is running, so the address-step and counter-step properties see only undisturbed progressions.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam int BUS_W = 16;
    localparam int NCHIP = 2;

    // register word indices
    localparam logic [5:0] RG_SYSCFG = 6'd0;
    localparam logic [5:0] RG_STATUS = 6'd1;
    localparam logic [5:0] RG_CTRL   = 6'd2;
    localparam logic [5:0] RG_PIXCNT = 6'd3;
    localparam logic [5:0] RG_LINE   = 6'd4;
    localparam logic [5:0] RG_CMD    = 6'd5;
    localparam logic [5:0] RG_PARAM  = 6'd6;
    localparam logic [5:0] RG_DATA   = 6'd7;
    localparam logic [5:0] RG_RDDATA = 6'd8;
    localparam logic [5:0] RG_RDSTAT = 6'd9;
    localparam logic [5:0] RG_CFG0   = 6'd10;
    localparam logic [5:0] RG_CFG1   = 6'd11;
    localparam logic [5:0] RG_DCYC0  = 6'd12;
    localparam int         NDCYC     = 6;
    localparam logic [5:0] RG_ONOFF0 = 6'd18;
    localparam logic [5:0] RG_ONOFF1 = 6'd19;
    localparam logic [5:0] RG_CYC0   = 6'd20;
    localparam logic [5:0] RG_CYC1   = 6'd21;
    localparam logic [5:0] RG_VSW    = 6'd22;
    localparam logic [5:0] RG_HSW    = 6'd23;

    localparam logic [31:0] SYSC_MASK  = 32'h0000_0019;
    localparam logic [31:0] CFG_MASK   = 32'h003F_1FFF;
    localparam logic [31:0] CFG_RESET  = 32'h0031_0000;
    localparam logic [31:0] DCYC_MASK  = 32'h0F1F_0F1F;
    localparam logic [31:0] ONOFF_MASK = 32'h3FFF_FFFF;
    localparam logic [31:0] CYC_MASK   = 32'h0FFF_FFFF;
    localparam logic [31:0] CFG_GATE   = 32'h0000_000C;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE} phase_e;
    typedef enum logic [1:0] {FR_IDLE, FR_STREAM, FR_DRAIN} frame_e;

    typedef struct packed {
        logic [NCHIP-1:0] cs;
        logic             dc;
        logic [BUS_W-1:0] data;
        logic             rd;
    } bus_req_t;

endpackage

// File: rtl/rfb_bus_seq.sv
module rfb_bus_seq
    import rfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  bus_req_t         req,
    output logic             busy,
    output logic             rd_done,
    output logic [BUS_W-1:0] rd_data,
    output logic [NCHIP-1:0] lcd_cs,
    output logic             lcd_dc,
    output logic [BUS_W-1:0] lcd_wdata,
    output logic             lcd_we,
    output logic             lcd_re,
    input  logic [BUS_W-1:0] lcd_rdata
);

    typedef struct packed {
        phase_e           ph;
        logic [NCHIP-1:0] cs;
        logic             dc;
        logic [BUS_W-1:0] wd;
        logic             rd;
        logic             we;
        logic             re;
        logic             done;
        logic [BUS_W-1:0] rx;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (go) begin
                    d.ph = PH_SETUP;
                    d.cs = req.cs;
                    d.dc = req.dc;
                    d.wd = req.data;
                    d.rd = req.rd;
                end
            end
            PH_SETUP: begin
                d.ph = PH_STROBE;
                d.we = ~q.rd;
                d.re = q.rd;
            end
            default: begin
                d.ph = PH_IDLE;
                d.we = 1'b0;
                d.re = 1'b0;
                d.cs = '0;
                if (q.rd) begin
                    d.done = 1'b1;
                    d.rx   = lcd_rdata;
                end
            end
        endcase
        if (clr) d = '{ph: PH_IDLE, default: '0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign busy      = (q.ph != PH_IDLE);
    assign rd_done   = q.done;
    assign rd_data   = q.rx;
    assign lcd_cs    = q.cs;
    assign lcd_dc    = q.dc;
    assign lcd_wdata = q.wd;
    assign lcd_we    = q.we;
    assign lcd_re    = q.re;

    assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_we |=> !lcd_we);
    assert_setup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_we |-> (lcd_cs != '0) && $stable(lcd_cs) && $stable(lcd_wdata) && $stable(lcd_dc));
    assert_read_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_re |-> $onehot(lcd_cs));

endmodule

// File: rtl/rfb_frame_ctl.sv
module rfb_frame_ctl
    import rfb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              zero_count,
    input  logic              last_word,
    input  logic [ADDR_W-1:0] base,
    input  logic [NCHIP-1:0]  cs_sel,
    input  logic              bus_idle,
    input  logic              mem_valid,
    output logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NCHIP-1:0]  frame_cs,
    output logic              active,
    output logic              take,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(BUS_W / 8);

    typedef struct packed {
        frame_e            st;
        logic [ADDR_W-1:0] addr;
        logic [NCHIP-1:0]  cs;
        logic              done;
    } fr_t;

    fr_t q, d;

    assign mem_ready = (q.st == FR_STREAM) && bus_idle;
    assign take      = mem_ready && mem_valid;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            FR_IDLE: begin
                if (start) begin
                    d.addr = base;
                    d.cs   = cs_sel;
                    d.st   = zero_count ? FR_DRAIN : FR_STREAM;
                end
            end
            FR_STREAM: begin
                if (take) begin
                    d.addr = q.addr + WORD_BYTES;
                    if (last_word) d.st = FR_DRAIN;
                end
            end
            default: begin
                if (bus_idle) begin
                    d.st   = FR_IDLE;
                    d.done = 1'b1;
                end
            end
        endcase
        if (clr) d = '{st: FR_IDLE, default: '0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_addr = q.addr;
    assign frame_cs = q.cs;
    assign active   = (q.st != FR_IDLE);
    assign done_o   = q.done;

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> (mem_addr == $past(mem_addr) + WORD_BYTES));

endmodule

// File: rtl/rfb_bridge.sv
module rfb_bridge
    import rfb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_ready,
    input  logic              disp_rfb_mode,
    input  logic [ADDR_W-1:0] gfx_base,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic              mem_ready,
    output logic              frame_done,
    output logic [1:0]        lcd_cs,
    output logic              lcd_dc,
    output logic [15:0]       lcd_wdata,
    output logic              lcd_we,
    output logic              lcd_re,
    input  logic [15:0]       lcd_rdata
);

    localparam int DC_IW = $clog2(NDCYC);

    typedef struct packed {
        logic [31:0]             sysc;
        logic [3:0]              ctrl;
        logic [PIX_W-1:0]        pix;
        logic [10:0]             line;
        logic [1:0][31:0]        cfg;
        logic [NDCYC-1:0][31:0]  dcyc;
        logic [1:0][31:0]        onoff;
        logic [1:0][31:0]        cyc;
        logic [15:0]             vsw;
        logic [15:0]             hsw;
        logic [BUS_W-1:0]        rxbuf;
        logic                    pend;
        logic [BUS_W-1:0]        pend_data;
        logic [NCHIP-1:0]        pend_cs;
    } top_t;

    function automatic top_t reset_val();
        top_t r;
        r        = '0;
        r.ctrl   = 4'h2;
        r.cfg[0] = CFG_RESET;
        r.cfg[1] = CFG_RESET;
        return r;
    endfunction

    top_t q, d;

    logic             seq_busy, seq_rd_done, seq_go;
    logic [BUS_W-1:0] seq_rd_data;
    bus_req_t         seq_req;
    logic             soft_clr, fr_start, fr_active, fr_take, fr_done;
    logic [NCHIP-1:0] fr_cs, sel, rd_cs;
    logic             is_bus, bus_idle, wr_ok, in_dcyc;
    logic [DC_IW-1:0] dc_idx;

    assign sel      = q.ctrl[3:2];
    assign rd_cs    = sel[0] ? 2'b01 : (sel[1] ? 2'b10 : 2'b00);
    assign is_bus   = (reg_addr >= RG_CMD) && (reg_addr <= RG_RDSTAT);
    assign bus_idle = !seq_busy && !q.pend;
    assign reg_ready = !(reg_wr && is_bus && (!bus_idle || fr_active));
    assign wr_ok    = reg_wr && reg_ready;
    assign in_dcyc  = (reg_addr >= RG_DCYC0) && (reg_addr < RG_DCYC0 + 6'(NDCYC));
    assign dc_idx   = DC_IW'(reg_addr - RG_DCYC0);

    always_comb begin
        d        = q;
        seq_go   = 1'b0;
        seq_req  = '0;
        soft_clr = 1'b0;
        fr_start = 1'b0;

        if (seq_rd_done) d.rxbuf = seq_rd_data;

        // bus cycle launch: split half first, then register, then frame
        if (!seq_busy && q.pend) begin
            seq_go  = 1'b1;
            seq_req = '{cs: q.pend_cs, dc: 1'b1, data: q.pend_data, rd: 1'b0};
            d.pend  = 1'b0;
        end else if (wr_ok && is_bus && (sel != '0)) begin
            seq_go = 1'b1;
            case (reg_addr)
                RG_CMD:   seq_req = '{cs: sel, dc: 1'b0, data: reg_wdata[15:0], rd: 1'b0};
                RG_PARAM: seq_req = '{cs: sel, dc: 1'b1, data: reg_wdata[15:0], rd: 1'b0};
                RG_DATA: begin
                    seq_req     = '{cs: sel, dc: 1'b1, data: reg_wdata[15:0], rd: 1'b0};
                    d.pend      = 1'b1;
                    d.pend_data = reg_wdata[31:16];
                    d.pend_cs   = sel;
                end
                RG_RDDATA: seq_req = '{cs: rd_cs, dc: 1'b1, data: '0, rd: 1'b1};
                default:   seq_req = '{cs: rd_cs, dc: 1'b0, data: '0, rd: 1'b1};
            endcase
        end else if (fr_take) begin
            seq_go  = 1'b1;
            seq_req = '{cs: fr_cs, dc: 1'b1, data: mem_rdata, rd: 1'b0};
        end

        if (fr_take) d.pix = q.pix - 1'b1;

        if (wr_ok) begin
            case (reg_addr)
                RG_SYSCFG: begin
                    if (reg_wdata[1]) begin
                        d        = reset_val();
                        soft_clr = 1'b1;
                    end
                    d.sysc = reg_wdata & SYSC_MASK;
                end
                RG_CTRL: begin
                    d.ctrl   = reg_wdata[3:0];
                    fr_start = reg_wdata[4] && reg_wdata[0] && !reg_wdata[1] && !fr_active
                               && disp_rfb_mode && ((q.cfg[0] & q.cfg[1] & CFG_GATE) == '0);
                end
                RG_PIXCNT: d.pix  = reg_wdata[PIX_W-1:0];
                RG_LINE:   d.line = reg_wdata[10:0];
                RG_DATA, RG_RDDATA, RG_RDSTAT: d.pix = q.pix - 1'b1;
                RG_CFG0, RG_CFG1:   d.cfg[reg_addr[0]]   = reg_wdata & CFG_MASK;
                RG_ONOFF0, RG_ONOFF1: d.onoff[reg_addr[0]] = reg_wdata & ONOFF_MASK;
                RG_CYC0, RG_CYC1:   d.cyc[reg_addr[0]]   = reg_wdata & CYC_MASK;
                RG_VSW: d.vsw = reg_wdata[15:0];
                RG_HSW: d.hsw = reg_wdata[15:0];
                default: if (in_dcyc) d.dcyc[dc_idx] = reg_wdata & DCYC_MASK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_val();
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RG_SYSCFG:            reg_rdata = q.sysc;
            RG_STATUS:            reg_rdata = {23'd0, fr_active, 7'd0, 1'b1};
            RG_CTRL:              reg_rdata = {28'd0, q.ctrl};
            RG_PIXCNT:            reg_rdata = 32'(q.pix);
            RG_LINE:              reg_rdata = {21'd0, q.line};
            RG_RDDATA, RG_RDSTAT: reg_rdata = {16'd0, q.rxbuf};
            RG_CFG0, RG_CFG1:     reg_rdata = q.cfg[reg_addr[0]];
            RG_ONOFF0, RG_ONOFF1: reg_rdata = q.onoff[reg_addr[0]];
            RG_CYC0, RG_CYC1:     reg_rdata = q.cyc[reg_addr[0]];
            RG_VSW:               reg_rdata = {16'd0, q.vsw};
            RG_HSW:               reg_rdata = {16'd0, q.hsw};
            default:              reg_rdata = in_dcyc ? q.dcyc[dc_idx] : 32'd0;
        endcase
    end

    rfb_bus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .go        (seq_go),
        .req       (seq_req),
        .busy      (seq_busy),
        .rd_done   (seq_rd_done),
        .rd_data   (seq_rd_data),
        .lcd_cs    (lcd_cs),
        .lcd_dc    (lcd_dc),
        .lcd_wdata (lcd_wdata),
        .lcd_we    (lcd_we),
        .lcd_re    (lcd_re),
        .lcd_rdata (lcd_rdata)
    );

    rfb_frame_ctl #(.ADDR_W(ADDR_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_clr),
        .start      (fr_start),
        .zero_count (q.pix == '0),
        .last_word  (q.pix == PIX_W'(1)),
        .base       (gfx_base),
        .cs_sel     (reg_wdata[3:2]),
        .bus_idle   (bus_idle),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .frame_cs   (fr_cs),
        .active     (fr_active),
        .take       (fr_take),
        .done_o     (fr_done)
    );

    assign frame_done = fr_done;

    assert_pix_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (reg_addr == RG_DATA)) |=> (q.pix == $past(q.pix) - 1'b1));
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> !seq_busy);

endmodule

// File: tb/rfb_bridge_test.sv
module rfb_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ready;
    logic        disp_rfb_mode = 1'b0;
    logic [31:0] gfx_base = '0;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [15:0] mem_rdata;
    logic        mem_ready;
    logic        frame_done;
    logic [1:0]  lcd_cs;
    logic        lcd_dc;
    logic [15:0] lcd_wdata;
    logic        lcd_we;
    logic        lcd_re;
    logic [15:0] lcd_rdata;
    logic        mem_en = 1'b0;

    always #2 clk = ~clk;

    rfb_bridge uut (.*);

    // memory and chip models
    assign mem_valid = mem_en;
    assign mem_rdata = mem_addr[15:0] ^ 16'hC3C3;
    assign lcd_rdata = lcd_cs[0] ? (lcd_dc ? 16'h1111 : 16'h3333)
                                 : (lcd_dc ? 16'h2222 : 16'h4444);

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    typedef struct packed {
        logic [1:0]  cs;
        logic        dc;
        logic [15:0] d;
    } item_t;
    item_t exp_q[$];

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] cs, input logic dc, input logic [15:0] dv);
        exp_q.push_back('{cs: cs, dc: dc, d: dv});
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        #1;
        while (!reg_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rchk(input logic [5:0] a, input logic [31:0] expv, input string rq);
        logic [31:0] v;
        rd(a, v);
        chk(v == expv, rq, v, expv);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) if (frame_done) done_cnt++;

    // monitor: pops expected bus writes and checks cycle shape (R6)
    logic [1:0]  p_cs = '0;
    logic        p_we = 1'b0;
    logic [15:0] p_d = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_we) chk(lcd_cs == 2'b00, "R6 cs release", {30'd0, lcd_cs}, 32'd0);
            if (lcd_we) begin
                chk(!p_we && p_cs == lcd_cs && p_d == lcd_wdata, "R6 setup",
                    {p_cs, p_d}, {lcd_cs, lcd_wdata});
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected cycle", {13'd0, lcd_cs, lcd_dc, lcd_wdata}, 32'd0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(e == {lcd_cs, lcd_dc, lcd_wdata}, "R3/R4/R5/R10 bus write",
                        {13'd0, lcd_cs, lcd_dc, lcd_wdata}, {13'd0, e});
                end
            end
            p_cs = lcd_cs; p_we = lcd_we; p_d = lcd_wdata;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1
        rchk(6'd2,  32'h2,          "R1 ctrl");
        rchk(6'd10, 32'h0031_0000,  "R1 cfg0");
        rchk(6'd11, 32'h0031_0000,  "R1 cfg1");
        rchk(6'd1,  32'h1,          "R1 status");
        rchk(6'd3,  32'h0,          "R1 pixcnt");

        // R2 masking
        wr(6'd0, 32'hFFFF_FFFF);
        rchk(6'd0, 32'h19, "R2 sysconfig");
        wr(6'd10, 32'hFFFF_FFFF); rchk(6'd10, 32'h003F_1FFF, "R2 cfg0");
        wr(6'd14, 32'hFFFF_FFFF); rchk(6'd14, 32'h0F1F_0F1F, "R2 dcyc");
        wr(6'd4,  32'hFFFF_FFFF); rchk(6'd4,  32'h7FF,       "R2 line");
        wr(6'd19, 32'hFFFF_FFFF); rchk(6'd19, 32'h3FFF_FFFF, "R2 onoff");
        wr(6'd20, 32'hFFFF_FFFF); rchk(6'd20, 32'h0FFF_FFFF, "R2 cycle");
        wr(6'd23, 32'hFFFF_FFFF); rchk(6'd23, 32'hFFFF,      "R2 hsync");
        wr(6'd2,  32'hFFFF_FFEF); rchk(6'd2,  32'hF,         "R2 ctrl");
        wr(6'd10, 32'h0031_0000);

        // R3 command to chip 0
        wr(6'd2, 32'h5);
        push(2'b01, 1'b0, 16'h1234);
        wr(6'd5, 32'hAAAA_1234);
        idle(6);
        chk(exp_q.size() == 0, "R3 command emitted", exp_q.size(), 0);

        // R4 parameter to both chips
        wr(6'd2, 32'hD);
        push(2'b11, 1'b1, 16'h00C7);
        wr(6'd6, 32'h5555_00C7);
        idle(6);
        chk(exp_q.size() == 0, "R4 parameter emitted", exp_q.size(), 0);

        // R5 data word, low half first; R8 decrement
        wr(6'd3, 32'd3);
        push(2'b11, 1'b1, 16'h4567);
        push(2'b11, 1'b1, 16'h89AB);
        wr(6'd7, 32'h89AB_4567);
        idle(10);
        chk(exp_q.size() == 0, "R5 two halves", exp_q.size(), 0);
        rchk(6'd3, 32'd2, "R8 data decrement");

        // R3 no chip selected: no cycle (monitor flags any)
        wr(6'd2, 32'h1);
        wr(6'd5, 32'h0000_0BAD);
        idle(8);
        rchk(6'd2, 32'h1, "R3 no chip");

        // R7 reads
        wr(6'd2, 32'hD);
        wr(6'd8, 32'h0);
        idle(6);
        rchk(6'd8, 32'h1111, "R7 data read chip0 priority");
        wr(6'd2, 32'h9);
        wr(6'd9, 32'h0);
        idle(6);
        rchk(6'd9, 32'h4444, "R7 status read chip1");
        rchk(6'd3, 32'd0, "R8 read decrement");

        // R8 wrap with no chip selected
        wr(6'd2, 32'h1);
        wr(6'd8, 32'h0);
        idle(2);
        rchk(6'd3, 32'hFFFF_FFFF, "R8 wrap");

        // R10/R12 frame with backpressure and a stalled command
        disp_rfb_mode = 1'b1;
        gfx_base = 32'h0000_1000;
        mem_en = 1'b0;
        d0 = done_cnt;
        wr(6'd3, 32'd4);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = 32'h1000 + 32'(2 * i);
            push(2'b01, 1'b1, a[15:0] ^ 16'hC3C3);
        end
        push(2'b01, 1'b0, 16'hBEEF);
        wr(6'd2, 32'h15);
        rchk(6'd1, 32'h101, "R10 busy during frame");
        fork
            wr(6'd5, 32'h0000_BEEF);
        join_none
        idle(4);
        #1;
        chk(!reg_ready, "R12 command stalled", {31'd0, reg_ready}, 32'd0);
        chk(exp_q.size() == 5, "R10 backpressure holds", exp_q.size(), 5);
        mem_en = 1'b1;
        wait fork;
        mem_en = 1'b0;
        idle(8);
        chk(exp_q.size() == 0, "R12 command after frame", exp_q.size(), 0);
        chk(done_cnt == d0 + 1, "R11 one done pulse", done_cnt, d0 + 1);
        rchk(6'd3, 32'd0, "R10 counter cleared");
        rchk(6'd1, 32'h1, "R10 busy cleared");

        // R9 blocking conditions
        d0 = done_cnt;
        wr(6'd3, 32'd2);
        disp_rfb_mode = 1'b0;
        wr(6'd2, 32'h15);
        idle(3);
        rchk(6'd1, 32'h1, "R9 no start without mode");
        disp_rfb_mode = 1'b1;
        wr(6'd10, 32'h4); wr(6'd11, 32'h4);
        wr(6'd2, 32'h15);
        idle(3);
        rchk(6'd1, 32'h1, "R9 no start with config gate");
        wr(6'd11, 32'h0);
        wr(6'd2, 32'h17);
        idle(3);
        rchk(6'd1, 32'h1, "R9 no start in bypass");
        wr(6'd2, 32'h14);
        idle(3);
        rchk(6'd1, 32'h1, "R9 no start when disabled");
        chk(done_cnt == d0, "R9 no done", done_cnt, d0);
        rchk(6'd3, 32'd2, "R9 counter untouched");

        // R11 zero-count frame
        wr(6'd3, 32'd0);
        wr(6'd2, 32'h15);
        idle(6);
        chk(done_cnt == d0 + 1, "R11 zero-count done", done_cnt, d0 + 1);
        chk(exp_q.size() == 0, "R11 zero-count no cycle", exp_q.size(), 0);

        // R13 soft reset
        wr(6'd4, 32'd5);
        wr(6'd0, 32'h1B);
        rchk(6'd0, 32'h19, "R13 sysconfig kept");
        rchk(6'd4, 32'h0,  "R13 line cleared");
        rchk(6'd2, 32'h2,  "R13 ctrl reset");
        rchk(6'd10, 32'h0031_0000, "R13 cfg reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule